// File: doc/BRIEF.md
# Setup Command Capture Buffer

This block stores the eight-byte request that arrives in the setup stage of a control transfer on endpoint 0. A packet-receive front end hands it a start-of-packet pulse and a flag that says whether the request is one the hardware answers on its own. It then delivers the data bytes one at a time and closes the packet with an end strobe and a good/bad status. Requests that the hardware answers itself never reach the storage. Every other request is written into an eight-entry memory. Firmware reads that memory through a byte-wide read port that walks an index from byte 0 upward.

A new setup request always wins. It is written over whatever is in the buffer, whether or not firmware has read it. If firmware is part-way through reading the previous request, a sticky status bit reports that the bytes it has read so far are no longer trustworthy. A setup-received flag rises only when exactly eight bytes arrive and the packet ends with good status. Firmware clears the flag by writing 1 to it.

Top module: `setup_cmd_buf`

## Requirements
- R1: After a synchronous reset, `setup_flag`, `rd_invalid` and `rd_ptr` are all 0. The contents of `fw_rd_data` are not defined.
- R2: A packet that is not hardware-handled, carries exactly 8 bytes and ends with `rx_eop` and `rx_eop_ok` both 1 sets `setup_flag` on the clock edge that samples the end strobe. Its bytes are then readable in arrival order, from index 0 to index 7.
- R3: A packet whose start pulse has `rx_hw_req` = 1 leaves the stored bytes, `setup_flag`, `rd_invalid` and `rd_ptr` unchanged.
- R4: A packet that ends with `rx_eop_ok` = 0, or that carries a byte count other than 8, does not set `setup_flag`. The stored contents are then undefined.
- R5: A new good packet replaces the stored request even when the earlier one was never read and `setup_flag` is still 1.
- R6: A one-cycle `fw_rd` pulse presents the byte at index `rd_ptr` on `fw_rd_data` one clock later. It also advances `rd_ptr` by one, and index 7 wraps to 0. Without `fw_rd`, `fw_rd_data` and `rd_ptr` hold.
- R7: A firmware-bound start pulse resets `rd_ptr` to 0. If `rd_ptr` was between 1 and 7 at that moment, it sets `rd_invalid`.
- R8: `rd_invalid` stays at 1 through failed packets and is cleared only when the next complete good command is stored.
- R9: Writing 1 to `fw_flag_clr` clears `setup_flag`. If a good command completes in the same cycle, the flag is set instead.
- R10: When a firmware-bound start pulse and `fw_rd` arrive in the same cycle, the start wins and `rd_ptr` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_setup_start | input | 1 | Pulse marking the start of a setup packet |
| rx_hw_req | input | 1 | With the start pulse: the request is handled in hardware |
| rx_byte_vld | input | 1 | Data byte valid |
| rx_byte | input | DW | Data byte |
| rx_eop | input | 1 | End of packet strobe |
| rx_eop_ok | input | 1 | With the end strobe: packet received without error |
| fw_rd | input | 1 | Firmware read strobe, one byte per pulse |
| fw_flag_clr | input | 1 | Firmware write-1 clear of the setup-received flag |
| fw_rd_data | output | DW | Registered read data |
| rd_ptr | output | $clog2(BYTES) | Index of the next byte to read |
| rd_invalid | output | 1 | The current firmware read was broken by a new capture |
| setup_flag | output | 1 | Setup-received flag |

## Verification
The bench builds the block with its defaults, BYTES = 8 and DW = 8. With those values the wrap of the read index from 7 to 0 shows up after a few reads, and packet lengths just short of and just beyond eight bytes are easy to drive. Random mixes of reads, clears and good, failed, wrong-length and hardware-handled packets often start a capture part-way through a read, so the invalidation path gets frequent exercise. Directed cases force the same-cycle collisions of set with clear and of start with read.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned SCB_BYTES = 8;
  localparam int unsigned SCB_DW    = 8;

  typedef enum logic [0:0] {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/scb_ram.sv
module scb_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: no reset on storage or output
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/scb_capture.sv
module scb_capture
  import scb_pkg::*;
#(
  parameter int unsigned BYTES = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(BYTES),
  localparam int unsigned CW   = $clog2(BYTES + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hw_req,
  input  logic          vld,
  input  logic [DW-1:0] din,
  input  logic          eop,
  input  logic          eop_ok,
  output logic          cap_start,
  output logic          done_good,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  cap_state_e     state;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  cnt_nxt;
  logic           take;
  logic           running;

  assign running   = (state == CAP_RUN) && !start;
  // count saturates one past the buffer size so an overlong packet is seen
  assign take      = running && vld && (cnt <= CW'(BYTES));
  assign cnt_nxt   = cnt + CW'(take);
  assign cap_start = start && !hw_req;
  assign done_good = running && eop && eop_ok && (cnt_nxt == CW'(BYTES));
  assign wr_en     = take && (cnt < CW'(BYTES));
  assign wr_addr   = cnt[AW-1:0];
  assign wr_data   = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CAP_IDLE;
      cnt   <= '0;
    end else if (start) begin
      // a hardware-handled request also ends any capture in progress
      state <= hw_req ? CAP_IDLE : CAP_RUN;
      cnt   <= '0;
    end else if (state == CAP_RUN) begin
      cnt <= cnt_nxt;
      if (eop) state <= CAP_IDLE;
    end
  end
endmodule

// File: rtl/scb_rdport.sv
module scb_rdport #(
  parameter int unsigned BYTES = 8,
  localparam int unsigned AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_start,
  input  logic          done_good,
  input  logic          fw_rd,
  output logic          rd_en,
  output logic [AW-1:0] ptr,
  output logic          invalid
);
  assign rd_en = fw_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      invalid <= 1'b0;
    end else begin
      if (cap_start)                     ptr <= '0;
      else if (fw_rd && ptr == AW'(BYTES - 1)) ptr <= '0;
      else if (fw_rd)                    ptr <= ptr + 1'b1;

      if (cap_start && ptr != '0) invalid <= 1'b1;
      else if (done_good)         invalid <= 1'b0;
    end
  end
endmodule

// File: rtl/setup_cmd_buf.sv
module setup_cmd_buf
  import scb_pkg::*;
#(
  parameter int unsigned BYTES = SCB_BYTES,
  parameter int unsigned DW    = SCB_DW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_setup_start,
  input  logic                     rx_hw_req,
  input  logic                     rx_byte_vld,
  input  logic [DW-1:0]            rx_byte,
  input  logic                     rx_eop,
  input  logic                     rx_eop_ok,
  input  logic                     fw_rd,
  input  logic                     fw_flag_clr,
  output logic [DW-1:0]            fw_rd_data,
  output logic [$clog2(BYTES)-1:0] rd_ptr,
  output logic                     rd_invalid,
  output logic                     setup_flag
);
  localparam int unsigned AW = $clog2(BYTES);

  logic          cap_start, done_good, wr_en, rd_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  scb_capture #(.BYTES(BYTES), .DW(DW)) cap_i (
    .clk(clk), .rst(rst), .start(rx_setup_start), .hw_req(rx_hw_req),
    .vld(rx_byte_vld), .din(rx_byte), .eop(rx_eop), .eop_ok(rx_eop_ok),
    .cap_start(cap_start), .done_good(done_good),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  scb_rdport #(.BYTES(BYTES)) rdp_i (
    .clk(clk), .rst(rst), .cap_start(cap_start), .done_good(done_good),
    .fw_rd(fw_rd), .rd_en(rd_en), .ptr(rd_ptr), .invalid(rd_invalid)
  );

  scb_ram #(.DEPTH(BYTES), .DW(DW)) ram_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_ptr), .rdata(fw_rd_data)
  );

  // set has priority over the firmware clear
  always_ff @(posedge clk) begin
    if (rst)              setup_flag <= 1'b0;
    else if (done_good)   setup_flag <= 1'b1;
    else if (fw_flag_clr) setup_flag <= 1'b0;
  end
endmodule

// File: rtl/setup_cmd_buf_chk.sv
module setup_cmd_buf_chk #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(BYTES)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_setup_start,
  input logic          rx_hw_req,
  input logic          rx_eop,
  input logic          rx_eop_ok,
  input logic          fw_rd,
  input logic          fw_flag_clr,
  input logic [DW-1:0] fw_rd_data,
  input logic [AW-1:0] rd_ptr,
  input logic          rd_invalid,
  input logic          setup_flag
);
  logic fw_start;
  assign fw_start = rx_setup_start && !rx_hw_req;

  // R2 / R4: the flag only rises after a good end of packet
  p_flag_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(setup_flag) |-> $past(rx_eop && rx_eop_ok));

  // R9: a clear with no end strobe in the same cycle drops the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (setup_flag && fw_flag_clr && !rx_eop) |=> !setup_flag);

  // R7 / R10: a firmware-bound start returns the index to 0
  p_ptr_restart_r7: assert property (@(posedge clk) disable iff (rst)
    fw_start |=> (rd_ptr == '0));

  // R7: a start during a partial read marks it invalid
  p_invalid_set_r7: assert property (@(posedge clk) disable iff (rst)
    (fw_start && rd_ptr != '0) |=> rd_invalid);

  // R6: the index walks by one per read and wraps
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (fw_rd && !fw_start) |=>
      (rd_ptr == (($past(rd_ptr) == AW'(BYTES - 1)) ? '0 : $past(rd_ptr) + 1'b1)));

  // R3 / R6: without a read or a firmware start the index holds
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!fw_rd && !fw_start) |=> $stable(rd_ptr));

  // R6: the read data only changes after a read strobe
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !fw_rd |=> $stable(fw_rd_data));

  // R8: the invalid bit cannot fall without a good end of packet
  p_invalid_keep_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_invalid) |-> $past(rx_eop && rx_eop_ok));
endmodule

bind setup_cmd_buf setup_cmd_buf_chk #(.BYTES(BYTES), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .rx_setup_start(rx_setup_start), .rx_hw_req(rx_hw_req),
  .rx_eop(rx_eop), .rx_eop_ok(rx_eop_ok), .fw_rd(fw_rd), .fw_flag_clr(fw_flag_clr),
  .fw_rd_data(fw_rd_data), .rd_ptr(rd_ptr), .rd_invalid(rd_invalid),
  .setup_flag(setup_flag)
);

// File: tb/setup_cmd_buf_tb_top.sv
module setup_cmd_buf_tb_top;
  localparam int BYTES = 8;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_setup_start = 0, rx_hw_req = 0, rx_byte_vld = 0;
  logic [DW-1:0] rx_byte = '0;
  logic rx_eop = 0, rx_eop_ok = 0, fw_rd = 0, fw_flag_clr = 0;
  logic [DW-1:0] fw_rd_data;
  logic [$clog2(BYTES)-1:0] rd_ptr;
  logic rd_invalid, setup_flag;

  always #10 clk = ~clk;

  setup_cmd_buf #(.BYTES(BYTES), .DW(DW)) dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] m_mem [BYTES];
  bit m_known = 0, m_flag = 0, m_inv = 0;
  int m_ptr = 0;

  function automatic int next_ptr(input int p);
    return (p == BYTES - 1) ? 0 : p + 1;
  endfunction

  function automatic bit is_good(input bit hw, input bit ok, input int n);
    return !hw && ok && (n == BYTES);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " flag"}, int'(setup_flag), int'(m_flag));
    check({req, " invalid"}, int'(rd_invalid), int'(m_inv));
    check({req, " ptr"}, int'(rd_ptr), m_ptr);
  endtask

  task automatic fw_read();
    int p = m_ptr;
    @(negedge clk); fw_rd = 1;
    @(negedge clk); fw_rd = 0;
    m_ptr = next_ptr(p);
    if (m_known) check("R6 data", int'(fw_rd_data), int'(m_mem[p]));
    check("R6 ptr", int'(rd_ptr), m_ptr);
  endtask

  task automatic fw_clear();
    @(negedge clk); fw_flag_clr = 1;
    @(negedge clk); fw_flag_clr = 0;
    m_flag = 0;
    check("R9 clear", int'(setup_flag), 0);
  endtask

  task automatic send_pkt(input bit hw, input bit ok, input int n,
                          input bit rd_start, input bit clr_end);
    logic [DW-1:0] pkt [16];
    string tag;
    for (int i = 0; i < 16; i++) pkt[i] = DW'($urandom);
    tag = hw ? "R3" : (is_good(hw, ok, n) ? "R2" : "R4");
    @(negedge clk);
    rx_setup_start = 1; rx_hw_req = hw; fw_rd = rd_start;
    @(negedge clk);
    rx_setup_start = 0; rx_hw_req = 0; fw_rd = 0;
    if (!hw) begin
      if (m_ptr != 0) m_inv = 1;
      m_ptr = 0;
      check(rd_start ? "R10 ptr" : "R7 ptr", int'(rd_ptr), 0);
      check("R7 invalid", int'(rd_invalid), int'(m_inv));
    end else if (rd_start) begin
      m_ptr = next_ptr(m_ptr);
    end
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1; rx_byte = pkt[i];
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_eop = 1; rx_eop_ok = ok; fw_flag_clr = clr_end;
    @(negedge clk);
    rx_eop = 0; rx_eop_ok = 0; fw_flag_clr = 0;
    if (is_good(hw, ok, n)) begin
      for (int i = 0; i < BYTES; i++) m_mem[i] = pkt[i];
      m_known = 1; m_flag = 1; m_inv = 0;
    end else begin
      if (!hw) m_known = 0;
      if (clr_end) m_flag = 0;
    end
    check_state(clr_end ? {tag, " R9 R8"} : {tag, " R8"});
  endtask

  initial begin
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("R1");

    // R2 / R6: good command, full read and wrap
    send_pkt(0, 1, BYTES, 0, 0);
    for (int i = 0; i < BYTES + 1; i++) fw_read();
    fw_clear();

    // R7 / R8: partial read broken by a failed packet, then a good one
    fw_read(); fw_read();
    send_pkt(0, 0, BYTES, 0, 0);
    check("R8 stays set", int'(rd_invalid), 1);
    send_pkt(0, 1, BYTES, 0, 0);
    check("R8 cleared", int'(rd_invalid), 0);

    // R4: wrong lengths
    fw_clear();
    send_pkt(0, 1, BYTES - 1, 0, 0);
    send_pkt(0, 1, BYTES + 1, 0, 0);

    // R5: overwrite of unread command
    send_pkt(0, 1, BYTES, 0, 0);
    send_pkt(0, 1, BYTES, 0, 0);
    for (int i = 0; i < BYTES; i++) fw_read();

    // R3: hardware-handled request leaves everything alone
    fw_read(); fw_read(); fw_read();
    send_pkt(1, 1, BYTES, 0, 0);
    for (int i = 0; i < BYTES; i++) fw_read();

    // R9: set and clear in the same cycle, set wins
    send_pkt(0, 1, BYTES, 0, 1);
    check("R9 set wins", int'(setup_flag), 1);

    // R10: start and read in the same cycle
    fw_read();
    send_pkt(0, 1, BYTES, 1, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 11));
      int n;
      case (op)
        0, 1, 2: send_pkt(0, 1, BYTES, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
        3:       send_pkt(1, $urandom_range(0, 1), int'($urandom_range(0, 10)), $urandom_range(0, 1), 0);
        4:       send_pkt(0, 0, int'($urandom_range(0, 10)), 0, $urandom_range(0, 1));
        5: begin
             n = int'($urandom_range(0, 10));
             if (n == BYTES) n = BYTES + 2;
             send_pkt(0, 1, n, 0, 0);
           end
        6:       fw_clear();
        default: fw_read();
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule